// File: doc/BRIEF.md
# Streaming TLP Header Decoder

This block watches a stream of transaction-layer packets that arrives one 32-bit word per cycle. Each word comes with a valid strobe, and start-of-packet and end-of-packet markers travel alongside it. The first byte of the leading word holds a 3-bit format code in bits 31:29 and a 5-bit type code in bits 28:24. From that pair the block classifies the packet, decides whether the header is three or four words long, notes whether a payload follows, and checks that the pair is a legal combination.

While the header streams in, the block stages it. On the final header word it commits the fields of the packet's family to registered outputs: request, configuration, completion or message. In the same step it pulses a done strobe that carries the type code, a non-posted flag and an unsupported-combination flag. Payload words after the header are not examined. If a packet ends before its header is complete, the block reports it as truncated.

Top module: `tlp_hdr_decoder`

## Requirements
- R1: On done, `dec_kind` reports the class: 0 mem read (type 00000, no data), 1 mem write (type 00000, data), 2 locked read (00001), 3 IO read, 4 IO write (00010), 5/6 cfg0 read/write (00100), 7/8 cfg1 read/write (00101), 9/10 completion without/with data (01010), 11/12 locked completion without/with data (01011), 13 fetch-add (01100), 14 swap (01101), 15 compare-swap (01110), 16 deferrable write (11011), 17/18 message without/with data (10xxx), 19 prefix (format 100), 31 unsupported.
- R2: On done, `dec_hdr_4dw` equals format bit 0 and `dec_has_data` equals format bit 1, for formats 000 to 011.
- R3: `dec_done` is high for the one cycle after the clock edge that accepts the last header word. That word is word 2 for format 000 or 010, word 3 for format 001 or 011, and word 0 for format 100 to 111. A packet gives at most one done, and payload words have no effect.
- R4: These combinations set `dec_unsup` with kind 31: type 00001 with a data format; type 00010, 00100, 00101, 01010 or 01011 with a 4-word format; types 01100 to 01110 or 11011 with a no-data format; any type code not listed in R1; and format 101 to 111.
- R5: `dec_nonposted` is 1 for kinds 0, 2 to 8 and 13 to 16. It is 0 for kinds 1, 9 to 12 and 17 to 19, and for unsupported packets.
- R6: For request-family headers (kinds 0 to 4 and 13 to 16), word 1 gives `req_id`=[31:16], `req_tag`=[15:8], `first_be`=[7:4] and `last_be`=[3:0]. `req_addr` is {32'h0, word2} for 3-word headers and {word2, word3} for 4-word headers.
- R7: For configuration kinds 5 to 8, word 1 gives requester ID, tag and byte enables as in R6. Word 2 gives `cfg_bus`=[31:24], `cfg_dev`=[23:19], `cfg_func`=[18:16], `cfg_ext_reg`=[11:8] and `cfg_reg`=[7:2].
- R8: For completion kinds 9 to 12, word 1 gives `cpl_id`=[31:16], `cpl_status`=[15:13], `cpl_bcm`=[12] and `cpl_byte_cnt`=[11:0]. Word 2 gives `req_id`=[31:16], `req_tag`=[15:8] and `cpl_low_addr`=[6:0].
- R9: For message kinds 17 and 18, word 1 gives `req_id`=[31:16], `req_tag`=[15:8] and `msg_code`=[7:0].
- R10: An end-of-packet marker on a header word before the last one pulses `dec_trunc` one cycle later. No done follows for that packet.
- R11: Captured fields change only on a done that is not unsupported, and only the fields of that packet's family change. Unsupported and truncated packets leave every field as it was.
- R12: A start-of-packet marker restarts decoding even in the middle of a header. Words without valid are skipped. Words without start-of-packet are ignored while no header is in progress.
- R13: After reset, `dec_done`, `dec_trunc`, the flags and all fields are 0, and `dec_kind` is 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_dw` is valid this cycle |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| in_dw | input | 32 | Packet word, first byte in bits 31:24 |
| dec_done | output | 1 | Header decoded (one-cycle pulse) |
| dec_trunc | output | 1 | Packet ended inside its header (pulse) |
| dec_unsup | output | 1 | Illegal format/type pair, held from last done |
| dec_kind | output | 5 | Packet class code, held from last done |
| dec_nonposted | output | 1 | Packet needs a completion |
| dec_hdr_4dw | output | 1 | Header is four words |
| dec_has_data | output | 1 | Payload follows the header |
| req_id | output | 16 | Requester ID |
| req_tag | output | 8 | Tag |
| first_be | output | 4 | First-word byte enables |
| last_be | output | 4 | Last-word byte enables |
| req_addr | output | 64 | Request address |
| cfg_bus | output | 8 | Configuration bus number |
| cfg_dev | output | 5 | Configuration device number |
| cfg_func | output | 3 | Configuration function number |
| cfg_ext_reg | output | 4 | Configuration extended register number |
| cfg_reg | output | 6 | Configuration register number |
| cpl_id | output | 16 | Completer ID |
| cpl_status | output | 3 | Completion status |
| cpl_bcm | output | 1 | Byte-count-modified bit |
| cpl_byte_cnt | output | 12 | Completion byte count |
| cpl_low_addr | output | 7 | Completion lower address |
| msg_code | output | 8 | Message code |

## Verification
The bench builds the decoder with `CAPTURE_CFG`, `CAPTURE_CPL` and `CAPTURE_MSG` all set to 1, so every family's field registers exist and can be compared against values worked out by hand. With all three enabled, one run can interleave families and confirm that a completion leaves the configuration fields alone, that a message leaves the address alone, and that rejected or truncated packets touch nothing. Those are the cross-family retention cases that only show up when every capture path is present.

// File: rtl/tlp_dec_pkg.sv
package tlp_dec_pkg;

    localparam int DW_W   = 32;
    localparam int ADDR_W = 64;

    typedef enum logic [4:0] {
        K_MRD    = 5'd0,
        K_MWR    = 5'd1,
        K_MRDLK  = 5'd2,
        K_IORD   = 5'd3,
        K_IOWR   = 5'd4,
        K_CFG0RD = 5'd5,
        K_CFG0WR = 5'd6,
        K_CFG1RD = 5'd7,
        K_CFG1WR = 5'd8,
        K_CPL    = 5'd9,
        K_CPLD   = 5'd10,
        K_CPLLK  = 5'd11,
        K_CPLDLK = 5'd12,
        K_FADD   = 5'd13,
        K_SWAP   = 5'd14,
        K_CAS    = 5'd15,
        K_DMWR   = 5'd16,
        K_MSG    = 5'd17,
        K_MSGD   = 5'd18,
        K_PREFIX = 5'd19,
        K_NONE   = 5'd31
    } kind_e;

    typedef enum logic [2:0] {
        LAY_NONE = 3'd0,
        LAY_REQ  = 3'd1,
        LAY_CFG  = 3'd2,
        LAY_CPL  = 3'd3,
        LAY_MSG  = 3'd4
    } layout_e;

    typedef struct packed {
        kind_e       kind;
        logic        unsup;
        logic        np;
        logic [2:0]  hdr_len;
        logic        hdr4;
        logic        data;
        layout_e     lay;
    } cls_t;

    localparam cls_t CLS_RESET = '{kind: K_NONE, unsup: 1'b0, np: 1'b0,
                                   hdr_len: 3'd1, hdr4: 1'b0, data: 1'b0,
                                   lay: LAY_NONE};

    function automatic cls_t classify(input logic [2:0] fmt, input logic [4:0] typ);
        cls_t c;
        logic four;
        logic wdat;
        four = fmt[0];
        wdat = fmt[1];
        c = CLS_RESET;
        if (fmt[2]) begin
            if (fmt == 3'b100) begin
                c.kind = K_PREFIX;
            end else begin
                c.unsup = 1'b1;
            end
        end else begin
            c.hdr_len = four ? 3'd4 : 3'd3;
            c.hdr4    = four;
            c.data    = wdat;
            if (typ[4:3] == 2'b10) begin
                c.kind = wdat ? K_MSGD : K_MSG;
                c.lay  = LAY_MSG;
            end else begin
                case (typ)
                    5'b00000: begin
                        c.kind = wdat ? K_MWR : K_MRD;
                        c.np   = !wdat;
                        c.lay  = LAY_REQ;
                    end
                    5'b00001: begin
                        c.unsup = wdat;
                        c.kind  = K_MRDLK;
                        c.np    = 1'b1;
                        c.lay   = LAY_REQ;
                    end
                    5'b00010: begin
                        c.unsup = four;
                        c.kind  = wdat ? K_IOWR : K_IORD;
                        c.np    = 1'b1;
                        c.lay   = LAY_REQ;
                    end
                    5'b00100: begin
                        c.unsup = four;
                        c.kind  = wdat ? K_CFG0WR : K_CFG0RD;
                        c.np    = 1'b1;
                        c.lay   = LAY_CFG;
                    end
                    5'b00101: begin
                        c.unsup = four;
                        c.kind  = wdat ? K_CFG1WR : K_CFG1RD;
                        c.np    = 1'b1;
                        c.lay   = LAY_CFG;
                    end
                    5'b01010: begin
                        c.unsup = four;
                        c.kind  = wdat ? K_CPLD : K_CPL;
                        c.lay   = LAY_CPL;
                    end
                    5'b01011: begin
                        c.unsup = four;
                        c.kind  = wdat ? K_CPLDLK : K_CPLLK;
                        c.lay   = LAY_CPL;
                    end
                    5'b01100: begin
                        c.unsup = !wdat;
                        c.kind  = K_FADD;
                        c.np    = 1'b1;
                        c.lay   = LAY_REQ;
                    end
                    5'b01101: begin
                        c.unsup = !wdat;
                        c.kind  = K_SWAP;
                        c.np    = 1'b1;
                        c.lay   = LAY_REQ;
                    end
                    5'b01110: begin
                        c.unsup = !wdat;
                        c.kind  = K_CAS;
                        c.np    = 1'b1;
                        c.lay   = LAY_REQ;
                    end
                    5'b11011: begin
                        c.unsup = !wdat;
                        c.kind  = K_DMWR;
                        c.np    = 1'b1;
                        c.lay   = LAY_REQ;
                    end
                    default: c.unsup = 1'b1;
                endcase
            end
        end
        if (c.unsup) begin
            c.kind = K_NONE;
            c.np   = 1'b0;
            c.lay  = LAY_NONE;
        end
        return c;
    endfunction

endpackage

// File: rtl/tlp_beat_tracker.sv
module tlp_beat_tracker
    import tlp_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic [DW_W-1:0] in_dw,
    output logic            hdr_fire,
    output logic            hdr_trunc,
    output cls_t            cls_cur,
    output logic [DW_W-1:0] dw1_q,
    output logic [DW_W-1:0] dw2_q
);

    logic       busy_q;
    logic [2:0] idx_q;
    cls_t       cls_q;
    cls_t       cls_new;
    logic [2:0] idx_eff;
    logic       live;
    logic       at_end;

    always_comb begin
        cls_new   = classify(in_dw[31:29], in_dw[28:24]);
        cls_cur   = in_sop ? cls_new : cls_q;
        idx_eff   = in_sop ? 3'd0 : idx_q;
        live      = in_valid && (in_sop || busy_q);
        at_end    = live && (idx_eff == (cls_cur.hdr_len - 3'd1));
        hdr_fire  = at_end;
        hdr_trunc = live && in_eop && !at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= 3'd0;
            cls_q  <= CLS_RESET;
            dw1_q  <= '0;
            dw2_q  <= '0;
        end else if (live) begin
            if (in_sop) begin
                cls_q <= cls_new;
            end
            if (at_end || in_eop) begin
                busy_q <= 1'b0;
            end else begin
                busy_q <= 1'b1;
                idx_q  <= idx_eff + 3'd1;
            end
            if (idx_eff == 3'd1) begin
                dw1_q <= in_dw;
            end
            if (idx_eff == 3'd2) begin
                dw2_q <= in_dw;
            end
        end
    end

endmodule

// File: rtl/tlp_field_capture.sv
module tlp_field_capture
    import tlp_dec_pkg::*;
#(
    parameter bit CAPTURE_CFG = 1'b1,
    parameter bit CAPTURE_CPL = 1'b1,
    parameter bit CAPTURE_MSG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  layout_e           lay,
    input  logic              hdr4,
    input  logic [DW_W-1:0]   w1,
    input  logic [DW_W-1:0]   w2,
    input  logic [DW_W-1:0]   w3,
    output logic [15:0]       req_id,
    output logic [7:0]        req_tag,
    output logic [3:0]        first_be,
    output logic [3:0]        last_be,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        cfg_bus,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_func,
    output logic [3:0]        cfg_ext_reg,
    output logic [5:0]        cfg_reg,
    output logic [15:0]       cpl_id,
    output logic [2:0]        cpl_status,
    output logic              cpl_bcm,
    output logic [11:0]       cpl_byte_cnt,
    output logic [6:0]        cpl_low_addr,
    output logic [7:0]        msg_code
);

    logic id_from_w1;
    logic id_from_w2;

    assign id_from_w1 = commit && (lay == LAY_REQ || lay == LAY_CFG || lay == LAY_MSG);
    assign id_from_w2 = commit && (lay == LAY_CPL);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_id   <= '0;
            req_tag  <= '0;
            first_be <= '0;
            last_be  <= '0;
            req_addr <= '0;
        end else begin
            if (id_from_w1) begin
                req_id  <= w1[31:16];
                req_tag <= w1[15:8];
            end else if (id_from_w2) begin
                req_id  <= w2[31:16];
                req_tag <= w2[15:8];
            end
            if (commit && (lay == LAY_REQ || lay == LAY_CFG)) begin
                first_be <= w1[7:4];
                last_be  <= w1[3:0];
            end
            if (commit && lay == LAY_REQ) begin
                req_addr <= hdr4 ? {w2, w3} : {{(ADDR_W-DW_W){1'b0}}, w2};
            end
        end
    end

    generate
        if (CAPTURE_CFG) begin : g_cfg
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_bus     <= '0;
                    cfg_dev     <= '0;
                    cfg_func    <= '0;
                    cfg_ext_reg <= '0;
                    cfg_reg     <= '0;
                end else if (commit && lay == LAY_CFG) begin
                    cfg_bus     <= w2[31:24];
                    cfg_dev     <= w2[23:19];
                    cfg_func    <= w2[18:16];
                    cfg_ext_reg <= w2[11:8];
                    cfg_reg     <= w2[7:2];
                end
            end
        end else begin : g_no_cfg
            assign cfg_bus     = '0;
            assign cfg_dev     = '0;
            assign cfg_func    = '0;
            assign cfg_ext_reg = '0;
            assign cfg_reg     = '0;
        end

        if (CAPTURE_CPL) begin : g_cpl
            always_ff @(posedge clk) begin
                if (rst) begin
                    cpl_id       <= '0;
                    cpl_status   <= '0;
                    cpl_bcm      <= 1'b0;
                    cpl_byte_cnt <= '0;
                    cpl_low_addr <= '0;
                end else if (commit && lay == LAY_CPL) begin
                    cpl_id       <= w1[31:16];
                    cpl_status   <= w1[15:13];
                    cpl_bcm      <= w1[12];
                    cpl_byte_cnt <= w1[11:0];
                    cpl_low_addr <= w2[6:0];
                end
            end
        end else begin : g_no_cpl
            assign cpl_id       = '0;
            assign cpl_status   = '0;
            assign cpl_bcm      = 1'b0;
            assign cpl_byte_cnt = '0;
            assign cpl_low_addr = '0;
        end

        if (CAPTURE_MSG) begin : g_msg
            always_ff @(posedge clk) begin
                if (rst) begin
                    msg_code <= '0;
                end else if (commit && lay == LAY_MSG) begin
                    msg_code <= w1[7:0];
                end
            end
        end else begin : g_no_msg
            assign msg_code = '0;
        end
    endgenerate

endmodule

// File: rtl/tlp_hdr_decoder.sv
module tlp_hdr_decoder
    import tlp_dec_pkg::*;
#(
    parameter bit CAPTURE_CFG = 1'b1,
    parameter bit CAPTURE_CPL = 1'b1,
    parameter bit CAPTURE_MSG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_sop,
    input  logic         in_eop,
    input  logic [31:0]  in_dw,
    output logic         dec_done,
    output logic         dec_trunc,
    output logic         dec_unsup,
    output logic [4:0]   dec_kind,
    output logic         dec_nonposted,
    output logic         dec_hdr_4dw,
    output logic         dec_has_data,
    output logic [15:0]  req_id,
    output logic [7:0]   req_tag,
    output logic [3:0]   first_be,
    output logic [3:0]   last_be,
    output logic [63:0]  req_addr,
    output logic [7:0]   cfg_bus,
    output logic [4:0]   cfg_dev,
    output logic [2:0]   cfg_func,
    output logic [3:0]   cfg_ext_reg,
    output logic [5:0]   cfg_reg,
    output logic [15:0]  cpl_id,
    output logic [2:0]   cpl_status,
    output logic         cpl_bcm,
    output logic [11:0]  cpl_byte_cnt,
    output logic [6:0]   cpl_low_addr,
    output logic [7:0]   msg_code
);

    logic            hdr_fire;
    logic            hdr_trunc;
    cls_t            cls_cur;
    logic [DW_W-1:0] dw1_q;
    logic [DW_W-1:0] dw2_q;
    logic [DW_W-1:0] hdr_w2;
    logic            commit;

    tlp_beat_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_dw     (in_dw),
        .hdr_fire  (hdr_fire),
        .hdr_trunc (hdr_trunc),
        .cls_cur   (cls_cur),
        .dw1_q     (dw1_q),
        .dw2_q     (dw2_q)
    );

    assign hdr_w2 = cls_cur.hdr4 ? dw2_q : in_dw;
    assign commit = hdr_fire && !cls_cur.unsup;

    tlp_field_capture #(
        .CAPTURE_CFG (CAPTURE_CFG),
        .CAPTURE_CPL (CAPTURE_CPL),
        .CAPTURE_MSG (CAPTURE_MSG)
    ) u_cap (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .lay          (cls_cur.lay),
        .hdr4         (cls_cur.hdr4),
        .w1           (dw1_q),
        .w2           (hdr_w2),
        .w3           (in_dw),
        .req_id       (req_id),
        .req_tag      (req_tag),
        .first_be     (first_be),
        .last_be      (last_be),
        .req_addr     (req_addr),
        .cfg_bus      (cfg_bus),
        .cfg_dev      (cfg_dev),
        .cfg_func     (cfg_func),
        .cfg_ext_reg  (cfg_ext_reg),
        .cfg_reg      (cfg_reg),
        .cpl_id       (cpl_id),
        .cpl_status   (cpl_status),
        .cpl_bcm      (cpl_bcm),
        .cpl_byte_cnt (cpl_byte_cnt),
        .cpl_low_addr (cpl_low_addr),
        .msg_code     (msg_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_done      <= 1'b0;
            dec_trunc     <= 1'b0;
            dec_unsup     <= 1'b0;
            dec_kind      <= K_NONE;
            dec_nonposted <= 1'b0;
            dec_hdr_4dw   <= 1'b0;
            dec_has_data  <= 1'b0;
        end else begin
            dec_done  <= hdr_fire;
            dec_trunc <= hdr_trunc;
            if (hdr_fire) begin
                dec_unsup     <= cls_cur.unsup;
                dec_kind      <= cls_cur.kind;
                dec_nonposted <= cls_cur.np;
                dec_hdr_4dw   <= cls_cur.hdr4;
                dec_has_data  <= cls_cur.data;
            end
        end
    end

endmodule

// File: rtl/tlp_hdr_decoder_chk.sv
module tlp_hdr_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        dec_done,
    input logic        dec_trunc,
    input logic        dec_unsup,
    input logic [4:0]  dec_kind,
    input logic        dec_nonposted,
    input logic [15:0] req_id,
    input logic [63:0] req_addr
);

    // R10
    done_trunc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        dec_trunc |-> !dec_done);

    // R3
    done_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
        dec_done |-> $past(in_valid));

    // R4
    unsup_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_done && dec_unsup) |-> (dec_kind == 5'd31));

    // R5
    unsup_posted_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_done && dec_unsup) |-> !dec_nonposted);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_done || dec_unsup) |-> $stable(req_addr));

    // R11
    id_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_done || dec_unsup) |-> $stable(req_id));

endmodule

bind tlp_hdr_decoder tlp_hdr_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .dec_done      (dec_done),
    .dec_trunc     (dec_trunc),
    .dec_unsup     (dec_unsup),
    .dec_kind      (dec_kind),
    .dec_nonposted (dec_nonposted),
    .req_id        (req_id),
    .req_addr      (req_addr)
);

// File: tb/tlp_hdr_decoder_bench.sv
`timescale 1ns/1ps
module tlp_hdr_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [31:0] in_dw = '0;

    logic        dec_done, dec_trunc, dec_unsup, dec_nonposted, dec_hdr_4dw, dec_has_data;
    logic [4:0]  dec_kind;
    logic [15:0] req_id;
    logic [7:0]  req_tag;
    logic [3:0]  first_be, last_be;
    logic [63:0] req_addr;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [3:0]  cfg_ext_reg;
    logic [5:0]  cfg_reg;
    logic [15:0] cpl_id;
    logic [2:0]  cpl_status;
    logic        cpl_bcm;
    logic [11:0] cpl_byte_cnt;
    logic [6:0]  cpl_low_addr;
    logic [7:0]  msg_code;

    always #5 clk = ~clk;

    tlp_hdr_decoder #(
        .CAPTURE_CFG (1'b1),
        .CAPTURE_CPL (1'b1),
        .CAPTURE_MSG (1'b1)
    ) u_tlp_hdr_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_dw(in_dw), .dec_done(dec_done), .dec_trunc(dec_trunc), .dec_unsup(dec_unsup),
        .dec_kind(dec_kind), .dec_nonposted(dec_nonposted), .dec_hdr_4dw(dec_hdr_4dw),
        .dec_has_data(dec_has_data), .req_id(req_id), .req_tag(req_tag),
        .first_be(first_be), .last_be(last_be), .req_addr(req_addr),
        .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func),
        .cfg_ext_reg(cfg_ext_reg), .cfg_reg(cfg_reg), .cpl_id(cpl_id),
        .cpl_status(cpl_status), .cpl_bcm(cpl_bcm), .cpl_byte_cnt(cpl_byte_cnt),
        .cpl_low_addr(cpl_low_addr), .msg_code(msg_code)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    int n_trunc = 0;
    logic [4:0] s_kind;
    logic       s_np, s_unsup, s_4dw, s_data;
    logic [31:0] pk [0:7];

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic sample();
        if (dec_done) begin
            n_done++;
            s_kind  = dec_kind;
            s_np    = dec_nonposted;
            s_unsup = dec_unsup;
            s_4dw   = dec_hdr_4dw;
            s_data  = dec_has_data;
        end
        if (dec_trunc) n_trunc++;
    endtask

    task automatic clear_counts();
        n_done  = 0;
        n_trunc = 0;
        s_kind  = 5'h1f;
        s_np    = 1'bx;
        s_unsup = 1'bx;
        s_4dw   = 1'bx;
        s_data  = 1'bx;
    endtask

    task automatic send(input int n, input bit with_sop, input bit with_eop, input int gap);
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    sample();
                    in_valid = 1'b0;
                end
            end
            @(negedge clk);
            sample();
            in_valid = 1'b1;
            in_sop   = with_sop && (i == 0);
            in_eop   = with_eop && (i == n - 1);
            in_dw    = pk[i];
        end
        @(negedge clk);
        sample();
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        @(negedge clk);
        sample();
    endtask

    task automatic t_reset();
        check("R13 done", dec_done, 0);
        check("R13 trunc", dec_trunc, 0);
        check("R13 kind", dec_kind, 31);
        check("R13 addr", req_addr, 0);
        check("R13 cpl_byte_cnt", cpl_byte_cnt, 0);
    endtask

    task automatic t_mem_read3();
        clear_counts();
        pk[0] = 32'h0000_2001; pk[1] = 32'h0000_200F; pk[2] = 32'hF620_000C;
        send(3, 1, 1, 0);
        check("R3 done count", n_done, 1);
        check("R1 kind mrd", s_kind, 0);
        check("R5 np mrd", s_np, 1);
        check("R2 4dw", s_4dw, 0);
        check("R2 data", s_data, 0);
        check("R6 req_id", req_id, 16'h0000);
        check("R6 tag", req_tag, 8'h20);
        check("R6 first_be", first_be, 4'h0);
        check("R6 last_be", last_be, 4'hF);
        check("R6 addr32", req_addr, 64'hF620_000C);
    endtask

    task automatic t_mem_write4();
        clear_counts();
        pk[0] = 32'h6000_9001; pk[1] = 32'h1357_21A5; pk[2] = 32'h0000_017F;
        pk[3] = 32'hC000_0000; pk[4] = 32'h0102_0304; pk[5] = 32'h6000_0000;
        send(6, 1, 1, 0);
        check("R3 payload no extra done", n_done, 1);
        check("R1 kind mwr", s_kind, 1);
        check("R5 np mwr", s_np, 0);
        check("R2 4dw", s_4dw, 1);
        check("R2 data", s_data, 1);
        check("R6 addr64", req_addr, 64'h0000_017F_C000_0000);
        check("R6 first_be", first_be, 4'hA);
        check("R6 last_be", last_be, 4'h5);
        check("R6 req_id", req_id, 16'h1357);
    endtask

    task automatic t_cfg();
        clear_counts();
        pk[0] = 32'h0400_0001; pk[1] = 32'h2001_FF0F; pk[2] = 32'hC281_FF10;
        send(3, 1, 1, 0);
        check("R1 kind cfg0rd", s_kind, 5);
        check("R5 np cfg", s_np, 1);
        check("R7 req_id", req_id, 16'h2001);
        check("R7 tag", req_tag, 8'hFF);
        check("R7 bus", cfg_bus, 8'hC2);
        check("R7 dev", cfg_dev, 5'h10);
        check("R7 func", cfg_func, 3'd1);
        check("R7 ext", cfg_ext_reg, 4'hF);
        check("R7 reg", cfg_reg, 6'd4);
        check("R11 addr kept by cfg", req_addr, 64'h0000_017F_C000_0000);
    endtask

    task automatic t_cpl();
        clear_counts();
        pk[0] = 32'h4A00_0001; pk[1] = 32'h2001_FF00; pk[2] = 32'hC281_FF10;
        pk[3] = 32'hFFFF_FFFF;
        send(4, 1, 1, 0);
        check("R1 kind cpld", s_kind, 10);
        check("R5 np cpl", s_np, 0);
        check("R8 cpl_id", cpl_id, 16'h2001);
        check("R8 status", cpl_status, 3'd7);
        check("R8 bcm", cpl_bcm, 1);
        check("R8 byte_cnt", cpl_byte_cnt, 12'hF00);
        check("R8 req_id", req_id, 16'hC281);
        check("R8 tag", req_tag, 8'hFF);
        check("R8 low_addr", cpl_low_addr, 7'h10);
        check("R11 cfg kept by cpl", cfg_bus, 8'hC2);
        check("R11 be kept by cpl", first_be, 4'h0);
    endtask

    task automatic t_atomics();
        clear_counts();
        pk[0] = 32'h4E00_0000; pk[1] = 32'hCAFE_1100; pk[2] = 32'h0000_1000;
        pk[3] = 32'h1111_2222; pk[4] = 32'h3333_4444;
        send(5, 1, 1, 0);
        check("R1 kind cas", s_kind, 15);
        check("R5 np cas", s_np, 1);
        check("R6 cas addr", req_addr, 64'h1000);
        check("R6 cas req_id", req_id, 16'hCAFE);
        clear_counts();
        pk[0] = 32'h6D00_0000; pk[1] = 32'hBEEF_A500; pk[2] = 32'h1122_3344;
        pk[3] = 32'h5566_7788; pk[4] = 32'h0102_0304; pk[5] = 32'h0506_0708;
        send(6, 1, 1, 0);
        check("R1 kind swap", s_kind, 14);
        check("R6 swap addr64", req_addr, 64'h1122_3344_5566_7788);
        check("R6 swap tag", req_tag, 8'hA5);
        clear_counts();
        pk[0] = 32'h4C00_0000; pk[1] = 32'h1234_5600; pk[2] = 32'h89AB_CDEF;
        pk[3] = 32'hDEAD_BEEF;
        send(4, 1, 1, 0);
        check("R1 kind fadd", s_kind, 13);
        check("R6 fadd addr", req_addr, 64'h89AB_CDEF);
    endtask

    task automatic t_dmwr();
        clear_counts();
        pk[0] = 32'h5B00_0000; pk[1] = 32'hABCD_420F; pk[2] = 32'hDEAD_0000;
        send(3, 1, 1, 0);
        check("R1 kind dmwr", s_kind, 16);
        check("R5 np dmwr", s_np, 1);
        check("R6 dmwr addr", req_addr, 64'hDEAD_0000);
        check("R6 dmwr tag", req_tag, 8'h42);
    endtask

    task automatic t_msg();
        clear_counts();
        pk[0] = 32'h3000_0000; pk[1] = 32'h7654_327F; pk[2] = 32'h0; pk[3] = 32'h0;
        send(4, 1, 1, 0);
        check("R1 kind msg", s_kind, 17);
        check("R5 np msg", s_np, 0);
        check("R9 msg_code", msg_code, 8'h7F);
        check("R9 req_id", req_id, 16'h7654);
        check("R9 tag", req_tag, 8'h32);
        check("R11 addr kept by msg", req_addr, 64'hDEAD_0000);
    endtask

    task automatic t_prefix();
        clear_counts();
        pk[0] = 32'h8000_0000;
        send(1, 1, 1, 0);
        check("R3 prefix done on word 0", n_done, 1);
        check("R1 kind prefix", s_kind, 19);
        check("R5 np prefix", s_np, 0);
        check("R4 prefix not unsup", s_unsup, 0);
    endtask

    task automatic expect_unsup(input string tag, input int n);
        clear_counts();
        send(n, 1, 1, 0);
        check({"R4 done ", tag}, n_done, 1);
        check({"R4 unsup ", tag}, s_unsup, 1);
        check({"R4 kind ", tag}, s_kind, 31);
        check({"R5 np ", tag}, s_np, 0);
        check({"R11 addr ", tag}, req_addr, 64'hDEAD_0000);
        check({"R11 id ", tag}, req_id, 16'h7654);
    endtask

    task automatic t_unsup();
        pk[0] = 32'h2200_0000; pk[1] = 32'h1111_1111; pk[2] = 32'h2222_2222; pk[3] = 32'h3333_3333;
        expect_unsup("io 4dw", 4);
        pk[0] = 32'h0C00_0000;
        expect_unsup("atomic nodata", 3);
        pk[0] = 32'h4100_0000;
        expect_unsup("lock with data", 3);
        pk[0] = 32'h0300_0000;
        expect_unsup("unknown type", 3);
        pk[0] = 32'h2A00_0000;
        expect_unsup("cpl 4dw", 4);
        pk[0] = 32'hA000_0000;
        expect_unsup("fmt 101", 1);
        pk[0] = 32'h7B00_0000;
        clear_counts();
        send(4, 1, 1, 0);
        check("R1 dmwr 4dw legal", s_kind, 16);
        check("R6 dmwr 4dw addr", req_addr, 64'h2222_2222_3333_3333);
    endtask

    task automatic t_trunc();
        clear_counts();
        pk[0] = 32'h0000_0001; pk[1] = 32'h0000_AA0F;
        send(2, 1, 1, 0);
        check("R10 trunc pulse", n_trunc, 1);
        check("R10 no done", n_done, 0);
        check("R11 addr kept on trunc", req_addr, 64'h2222_2222_3333_3333);
        clear_counts();
        pk[0] = 32'h0000_0001;
        send(1, 1, 1, 0);
        check("R10 trunc on sop+eop", n_trunc, 1);
    endtask

    task automatic t_restart();
        clear_counts();
        pk[0] = 32'h6000_0001; pk[1] = 32'h9999_9999;
        send(2, 1, 0, 0);
        pk[0] = 32'h0000_0001; pk[1] = 32'h4321_0011; pk[2] = 32'h0BAD_F00D;
        send(3, 1, 1, 0);
        check("R12 restart single done", n_done, 1);
        check("R12 restart kind", s_kind, 0);
        check("R12 restart addr", req_addr, 64'h0BAD_F00D);
    endtask

    task automatic t_gap();
        clear_counts();
        pk[0] = 32'h2000_0001; pk[1] = 32'h5555_66F3; pk[2] = 32'hAAAA_0000; pk[3] = 32'h0000_BBBB;
        send(4, 1, 1, 2);
        check("R12 gap done", n_done, 1);
        check("R12 gap addr", req_addr, 64'hAAAA_0000_0000_BBBB);
        check("R12 gap 4dw", s_4dw, 1);
    endtask

    task automatic t_stray();
        clear_counts();
        pk[0] = 32'h0000_0001; pk[1] = 32'hFFFF_FFFF; pk[2] = 32'h1234_5678;
        send(3, 0, 1, 0);
        check("R12 stray no done", n_done, 0);
        check("R12 stray no trunc", n_trunc, 0);
        check("R12 stray addr kept", req_addr, 64'hAAAA_0000_0000_BBBB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mem_read3();
        t_mem_write4();
        t_cfg();
        t_cpl();
        t_atomics();
        t_dmwr();
        t_msg();
        t_prefix();
        t_unsup();
        t_trunc();
        t_restart();
        t_gap();
        t_stray();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule